// File: doc/BRIEF.md
# Genlockable Video Sync Timing Generator

This block derives horizontal and vertical video timing from the video clock. A horizontal counter steps once per clock. A vertical counter steps once per line. Programmable compare values turn the two counts into active-low sync pulses and a combined blanking flag. The current counts are also brought out, so that a pixel pipeline can use them directly.

Each sync pad can work in one of two ways. In drive mode the block is the timing master and drives its own sync pulse onto the pad. In follow mode the pad is an input. Each falling edge there re-phases the matching counter, so the block locks to an external master. For horizontal lock, the counter is loaded with a programmed offset in clocks. For vertical lock, the counter is loaded with a programmed offset in lines at the next line end. The offsets absorb any pipeline delay between the external timing source and this block.

Timing values are written through a simple write-only register port. They land in a staging copy and move into the working copy together at the next frame start. The direction bits act at once.

Top module: `genlock_sync_gen`

Register map (address on `cfg_addr`, value on `cfg_wdata`):

| Addr | Meaning |
|------|---------|
| 0 | direction: bit0 = horizontal pad driven, bit1 = vertical pad driven (1 = drive, 0 = follow) |
| 1 | line total (last horizontal count value) |
| 2 | horizontal sync end |
| 3 | horizontal blank end (first visible clock) |
| 4 | horizontal blank start (first blanked clock after the visible part) |
| 5 | horizontal lock offset |
| 6 | frame total (last line number) |
| 7 | vertical sync end |
| 8 | vertical blank end |
| 9 | vertical blank start |
| 10 | vertical lock offset |

## Requirements
- R1: While reset is held and right after it, both pad enables are low, both sync outputs are high and both counters read zero. The working timing values are the parameter defaults.
- R2: The horizontal count rises by one each clock. On the clock after it reaches or exceeds the line total, it goes to zero. An out-of-range value (above the total) therefore returns to zero after one clock.
- R3: The vertical count changes only at a horizontal wrap. There it rises by one, or goes to zero if it had reached or exceeded the frame total.
- R4: A pad in drive mode (direction bit 1) has its enable high. Its sync output is low while its count is below the sync end value and high otherwise. A pad in follow mode has its enable low and its sync output held high.
- R5: `blank` is high when the horizontal count is below the horizontal blank end or at or above the horizontal blank start. It is also high when the same holds for the vertical count and its vertical limits.
- R6: A write to addresses 1 to 10 changes no output until the next frame start. At that point all staged values take effect together. A write to address 0 changes the pad directions from the next clock.
- R7: In horizontal follow mode the pad passes a two-flop synchronizer. A falling edge (high then low, as synchronized) loads the horizontal count with the horizontal offset. When the pad is first low at clock edge k, the count equals the offset after edge k+2. No line end is produced by that load.
- R8: In vertical follow mode a synchronized falling edge arms a vertical lock. At the next horizontal wrap, including one in the same clock as the detection, the vertical count is loaded with the vertical offset instead of stepping. The arming is cleared when it is used or when the pad is switched to drive mode.
- R9: Edges on a pad in drive mode have no effect on the counters.
- R10: A frame start is a horizontal wrap at which the vertical count either wraps to zero or is loaded by a vertical lock. Staged timing values are applied at either kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vid_clk | input | 1 | Video clock; every register in the block uses it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | CW | Register write value |
| hs_pad_in | input | 1 | Horizontal sync as seen at the pad |
| vs_pad_in | input | 1 | Vertical sync as seen at the pad |
| hs_pad_out | output | 1 | Horizontal sync drive value, active low |
| hs_pad_oe | output | 1 | Horizontal pad output enable |
| vs_pad_out | output | 1 | Vertical sync drive value, active low |
| vs_pad_oe | output | 1 | Vertical pad output enable |
| blank | output | 1 | Blanking flag, high outside the visible area |
| hcount | output | CW | Horizontal count in clocks |
| vcount | output | CW | Vertical count in lines |

Named states: the configuration staging machine has `CFG_CLEAN` (working copy equals staging copy) and `CFG_PENDING` (staged values wait). Its transitions are CLEAN→PENDING on a timing write, PENDING→CLEAN at a frame start with no write, and PENDING→PENDING otherwise. The vertical lock machine has `LOCK_IDLE` and `LOCK_ARMED`. Its transitions are IDLE→ARMED on a follow-mode falling edge away from a line end, ARMED→IDLE at a line end or on a switch to drive mode, and a direct IDLE→IDLE load when the edge meets a line end.

## Verification
The counters are first run free with both pads quiet, which separates correct wrap points from off-by-one totals. Next they run in drive mode while the pads toggle at random, which shows whether drive mode really ignores the pads. Timing values are rewritten in the middle of a frame, which tells apart staging at the frame boundary from immediate update. Single falling edges on each pad, plus random pulse trains of uneven spacing, show the synchronizer latency and the horizontal and vertical offset loads. An offset above the line total checks the return to zero.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    // Working-copy slot indices; bus address of a slot is index + 1
    localparam int IDX_HTOTAL  = 0;
    localparam int IDX_HSEND   = 1;
    localparam int IDX_HBEND   = 2;
    localparam int IDX_HBSTART = 3;
    localparam int IDX_HOFF    = 4;
    localparam int IDX_VTOTAL  = 5;
    localparam int IDX_VSEND   = 6;
    localparam int IDX_VBEND   = 7;
    localparam int IDX_VBSTART = 8;
    localparam int IDX_VOFF    = 9;
    localparam int NUM_TIMING  = 10;

    localparam int ADDR_DIR    = 0;

    typedef enum logic {
        CFG_CLEAN,
        CFG_PENDING
    } cfg_state_e;

    typedef enum logic {
        LOCK_IDLE,
        LOCK_ARMED
    } lock_state_e;

endpackage

// File: rtl/vtg_cfg_regs.sv
module vtg_cfg_regs
    import vtg_pkg::*;
#(
    parameter int CW            = 12,
    parameter int AW            = 4,
    parameter int H_TOTAL       = 799,
    parameter int H_SYNC_END    = 96,
    parameter int H_BLANK_END   = 144,
    parameter int H_BLANK_START = 784,
    parameter int H_OFFSET      = 0,
    parameter int V_TOTAL       = 524,
    parameter int V_SYNC_END    = 2,
    parameter int V_BLANK_END   = 35,
    parameter int V_BLANK_START = 515,
    parameter int V_OFFSET      = 0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [AW-1:0]                    addr,
    input  logic [CW-1:0]                    wdata,
    input  logic                             frame_start,
    output logic                             h_drive,
    output logic                             v_drive,
    output logic [NUM_TIMING-1:0][CW-1:0]    work
);

    localparam logic [NUM_TIMING-1:0][CW-1:0] DEFAULTS = {
        CW'(V_OFFSET), CW'(V_BLANK_START), CW'(V_BLANK_END), CW'(V_SYNC_END), CW'(V_TOTAL),
        CW'(H_OFFSET), CW'(H_BLANK_START), CW'(H_BLANK_END), CW'(H_SYNC_END), CW'(H_TOTAL)
    };

    logic [NUM_TIMING-1:0][CW-1:0] stage;
    logic                          timing_wr;
    logic                          apply_now;
    cfg_state_e                    state_q, state_d;

    assign timing_wr = we && (addr >= AW'(1)) && (addr <= AW'(NUM_TIMING));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_CLEAN;
        else        state_q <= state_d;
    end

    // Next state and outputs of the staging machine
    always_comb begin
        state_d   = state_q;
        apply_now = 1'b0;
        unique case (state_q)
            CFG_CLEAN: begin
                if (timing_wr) state_d = CFG_PENDING;
            end
            CFG_PENDING: begin
                apply_now = frame_start;
                if (timing_wr)        state_d = CFG_PENDING;
                else if (frame_start) state_d = CFG_CLEAN;
            end
        endcase
    end

    // Direction bits act immediately
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_drive <= 1'b0;
            v_drive <= 1'b0;
        end else if (we && addr == AW'(ADDR_DIR)) begin
            h_drive <= wdata[0];
            v_drive <= wdata[1];
        end
    end

    // One staging slot and one working slot per timing value
    for (genvar i = 0; i < NUM_TIMING; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[i] <= DEFAULTS[i];
                work[i]  <= DEFAULTS[i];
            end else begin
                if (we && addr == AW'(i + 1)) stage[i] <= wdata;
                if (apply_now)                work[i]  <= stage[i];
            end
        end
    end

    // R6: working copy only moves at a frame start
    assert_work_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(work));

    // R10: pending values are taken over at a frame start
    assert_apply_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && state_q == CFG_PENDING) |=> work == $past(stage));

endmodule

// File: rtl/vtg_edge_sampler.sv
module vtg_edge_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= 1'b1;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[LAST];
    end

    assign fall = prev & ~chain[LAST];

    // R7: a single edge never yields two detections in a row
    assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [CW-1:0] total,
    input  logic [CW-1:0] sync_end,
    input  logic [CW-1:0] blank_end,
    input  logic [CW-1:0] blank_start,
    output logic [CW-1:0] count,
    output logic          wrap,
    output logic          in_sync,
    output logic          in_blank
);

    assign wrap = advance && !load && (count >= total);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (load)    count <= load_val;
        else if (wrap)    count <= '0;
        else if (advance) count <= count + 1'b1;
    end

    assign in_sync  = count < sync_end;
    assign in_blank = (count < blank_end) || (count >= blank_start);

    // R2 (horizontal instance) and R3 (vertical instance): return to zero
    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && count >= total) |=> count == '0);

    // R2 / R3: single step below the total
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && count < total) |=> count == $past(count) + 1'b1);

    // R7 / R8: lock load takes the offset
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));

endmodule

// File: rtl/vtg_vlock.sv
module vtg_vlock
    import vtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic follow,
    input  logic edge_seen,
    input  logic line_end,
    output logic apply
);

    lock_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LOCK_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOCK_IDLE: begin
                if (follow && edge_seen && !line_end) state_d = LOCK_ARMED;
            end
            LOCK_ARMED: begin
                if (!follow || line_end) state_d = LOCK_IDLE;
            end
        endcase
    end

    // Output
    always_comb begin
        apply = 1'b0;
        unique case (state_q)
            LOCK_IDLE:  apply = follow && edge_seen && line_end;
            LOCK_ARMED: apply = follow && line_end;
        endcase
    end

    // R8: arming is used up at the line end
    assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LOCK_ARMED && line_end) |=> state_q == LOCK_IDLE);

    // R8: switching to drive mode drops the arming
    assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !follow |=> state_q == LOCK_IDLE);

endmodule

// File: rtl/genlock_sync_gen.sv
module genlock_sync_gen
    import vtg_pkg::*;
#(
    parameter int CW            = 12,
    parameter int SYNC_STAGES   = 2,
    parameter int H_TOTAL       = 799,
    parameter int H_SYNC_END    = 96,
    parameter int H_BLANK_END   = 144,
    parameter int H_BLANK_START = 784,
    parameter int H_OFFSET      = 0,
    parameter int V_TOTAL       = 524,
    parameter int V_SYNC_END    = 2,
    parameter int V_BLANK_END   = 35,
    parameter int V_BLANK_START = 515,
    parameter int V_OFFSET      = 0
) (
    input  logic          vid_clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          hs_pad_in,
    input  logic          vs_pad_in,
    output logic          hs_pad_out,
    output logic          hs_pad_oe,
    output logic          vs_pad_out,
    output logic          vs_pad_oe,
    output logic          blank,
    output logic [CW-1:0] hcount,
    output logic [CW-1:0] vcount
);

    logic [NUM_TIMING-1:0][CW-1:0] work;
    logic h_drive, v_drive;
    logic h_fall, v_fall;
    logic h_load, v_apply;
    logic line_end, v_wrap, frame_start;
    logic h_sync, h_blank, v_sync, v_blank;

    vtg_cfg_regs #(
        .CW(CW), .AW(4),
        .H_TOTAL(H_TOTAL), .H_SYNC_END(H_SYNC_END), .H_BLANK_END(H_BLANK_END),
        .H_BLANK_START(H_BLANK_START), .H_OFFSET(H_OFFSET),
        .V_TOTAL(V_TOTAL), .V_SYNC_END(V_SYNC_END), .V_BLANK_END(V_BLANK_END),
        .V_BLANK_START(V_BLANK_START), .V_OFFSET(V_OFFSET)
    ) u_cfg (
        .clk(vid_clk), .rst_n(rst_n),
        .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .frame_start(frame_start),
        .h_drive(h_drive), .v_drive(v_drive),
        .work(work)
    );

    vtg_edge_sampler #(.STAGES(SYNC_STAGES)) u_hs_edge (
        .clk(vid_clk), .rst_n(rst_n), .pin(hs_pad_in), .fall(h_fall)
    );

    vtg_edge_sampler #(.STAGES(SYNC_STAGES)) u_vs_edge (
        .clk(vid_clk), .rst_n(rst_n), .pin(vs_pad_in), .fall(v_fall)
    );

    assign h_load = !h_drive && h_fall;

    vtg_axis #(.CW(CW)) u_h_axis (
        .clk(vid_clk), .rst_n(rst_n),
        .advance(1'b1), .load(h_load), .load_val(work[IDX_HOFF]),
        .total(work[IDX_HTOTAL]), .sync_end(work[IDX_HSEND]),
        .blank_end(work[IDX_HBEND]), .blank_start(work[IDX_HBSTART]),
        .count(hcount), .wrap(line_end), .in_sync(h_sync), .in_blank(h_blank)
    );

    vtg_vlock u_vlock (
        .clk(vid_clk), .rst_n(rst_n),
        .follow(!v_drive), .edge_seen(v_fall), .line_end(line_end),
        .apply(v_apply)
    );

    vtg_axis #(.CW(CW)) u_v_axis (
        .clk(vid_clk), .rst_n(rst_n),
        .advance(line_end), .load(v_apply), .load_val(work[IDX_VOFF]),
        .total(work[IDX_VTOTAL]), .sync_end(work[IDX_VSEND]),
        .blank_end(work[IDX_VBEND]), .blank_start(work[IDX_VBSTART]),
        .count(vcount), .wrap(v_wrap), .in_sync(v_sync), .in_blank(v_blank)
    );

    assign frame_start = v_wrap || v_apply;

    assign hs_pad_oe  = h_drive;
    assign vs_pad_oe  = v_drive;
    assign hs_pad_out = h_drive ? !h_sync : 1'b1;
    assign vs_pad_out = v_drive ? !v_sync : 1'b1;
    assign blank      = h_blank || v_blank;

    // R3: vertical count holds between line ends
    assert_vstill_R3: assert property (@(posedge vid_clk) disable iff (!rst_n)
        !line_end |=> $stable(vcount));

    // R9: a driven pad never re-phases the horizontal count
    assert_drive_ignore_R9: assert property (@(posedge vid_clk) disable iff (!rst_n)
        (hs_pad_oe && hcount < work[IDX_HTOTAL]) |=> hcount == $past(hcount) + 1'b1);

endmodule

// File: tb/genlock_sync_gen_bench.sv
module genlock_sync_gen_bench;

    localparam int CW = 12;

    logic          vid_clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [3:0]    cfg_addr;
    logic [CW-1:0] cfg_wdata;
    logic          hs_pad_in, vs_pad_in;
    logic          hs_pad_out, hs_pad_oe, vs_pad_out, vs_pad_oe, blank;
    logic [CW-1:0] hcount, vcount;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    bit run_model = 0;

    always #4 vid_clk = ~vid_clk;

    genlock_sync_gen #(
        .CW(CW),
        .H_TOTAL(19), .H_SYNC_END(3), .H_BLANK_END(5), .H_BLANK_START(17), .H_OFFSET(0),
        .V_TOTAL(9), .V_SYNC_END(1), .V_BLANK_END(2), .V_BLANK_START(8), .V_OFFSET(0)
    ) u_genlock_sync_gen (
        .vid_clk(vid_clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hs_pad_in(hs_pad_in), .vs_pad_in(vs_pad_in),
        .hs_pad_out(hs_pad_out), .hs_pad_oe(hs_pad_oe),
        .vs_pad_out(vs_pad_out), .vs_pad_oe(vs_pad_oe),
        .blank(blank), .hcount(hcount), .vcount(vcount)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_h, m_v;
    bit m_hdrv, m_vdrv, m_armed, m_pend;
    int m_work[10];
    int m_stage[10];
    bit hs_hist[$];
    bit vs_hist[$];
    int defaults[10] = '{19, 3, 5, 17, 0, 9, 1, 2, 8, 0};

    task automatic model_reset();
        m_h = 0; m_v = 0; m_hdrv = 0; m_vdrv = 0; m_armed = 0; m_pend = 0;
        foreach (defaults[i]) begin
            m_work[i]  = defaults[i];
            m_stage[i] = defaults[i];
        end
        hs_hist = '{1'b1, 1'b1, 1'b1};
        vs_hist = '{1'b1, 1'b1, 1'b1};
    endtask

    task automatic model_step();
        bit hfall, vfall, hload, lend, vapply, vwrap, fs;
        int nh, nv;
        hfall  = hs_hist[2] && !hs_hist[1];
        vfall  = vs_hist[2] && !vs_hist[1];
        hload  = !m_hdrv && hfall;
        lend   = !hload && (m_h >= m_work[0]);
        vapply = lend && !m_vdrv && (m_armed || vfall);
        vwrap  = lend && !vapply && (m_v >= m_work[5]);
        fs     = vwrap || vapply;
        nh = hload ? m_work[4] : (lend ? 0 : m_h + 1);
        nv = vapply ? m_work[9] : (lend ? (vwrap ? 0 : m_v + 1) : m_v);
        m_armed = !m_vdrv && !lend && (m_armed || vfall);
        if (fs && m_pend) foreach (m_work[i]) m_work[i] = m_stage[i];
        if (cfg_we && cfg_addr == 4'd0) begin
            m_hdrv = cfg_wdata[0];
            m_vdrv = cfg_wdata[1];
        end
        if (cfg_we && cfg_addr >= 4'd1 && cfg_addr <= 4'd10) begin
            m_stage[cfg_addr - 1] = int'(cfg_wdata);
            m_pend = 1;
        end else if (fs) begin
            m_pend = 0;
        end
        m_h = nh % (1 << CW);
        m_v = nv % (1 << CW);
        hs_hist.push_front(hs_pad_in); void'(hs_hist.pop_back());
        vs_hist.push_front(vs_pad_in); void'(vs_hist.pop_back());
    endtask

    always @(posedge vid_clk) begin
        bit eb;
        if (!rst_n) model_reset();
        else        model_step();
        #2;
        if (rst_n && run_model && !finished) begin
            check(hcount == CW'(m_h), "R2 R6 R7 R9 hcount", int'(hcount), m_h);
            check(vcount == CW'(m_v), "R3 R8 R10 vcount", int'(vcount), m_v);
            check(hs_pad_oe == m_hdrv, "R4 R6 hs_pad_oe", hs_pad_oe, m_hdrv);
            check(vs_pad_oe == m_vdrv, "R4 R6 vs_pad_oe", vs_pad_oe, m_vdrv);
            check(hs_pad_out == (m_hdrv ? !(m_h < m_work[1]) : 1'b1), "R4 hs_pad_out",
                  hs_pad_out, m_hdrv ? !(m_h < m_work[1]) : 1);
            check(vs_pad_out == (m_vdrv ? !(m_v < m_work[6]) : 1'b1), "R4 vs_pad_out",
                  vs_pad_out, m_vdrv ? !(m_v < m_work[6]) : 1);
            eb = (m_h < m_work[2]) || (m_h >= m_work[3]) || (m_v < m_work[7]) || (m_v >= m_work[8]);
            check(blank == eb, "R5 blank", blank, eb);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge vid_clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = CW'(d);
        @(negedge vid_clk);
        cfg_we = 1'b0;
    endtask

    task automatic sample();
        @(posedge vid_clk); #2;
    endtask

    task automatic wait_frame();
        do sample(); while (vcount == 0);
        do sample(); while (!(vcount == 0 && hcount == 0));
    endtask

    task automatic random_pins(input int cycles, input bit do_h, input bit do_v);
        for (int c = 0; c < cycles; c++) begin
            @(negedge vid_clk);
            if (do_h && $urandom_range(0, 7) == 0) hs_pad_in = ~hs_pad_in;
            if (do_v && $urandom_range(0, 15) == 0) vs_pad_in = ~vs_pad_in;
        end
        @(negedge vid_clk);
        hs_pad_in = 1'b1; vs_pad_in = 1'b1;
        repeat (4) @(negedge vid_clk);
    endtask

    task automatic h_pulse_check(input int expect_off);
        @(negedge vid_clk);
        hs_pad_in = 1'b0;
        repeat (3) sample();
        check(hcount == CW'(expect_off), "R7 lock load", int'(hcount), expect_off);
        @(negedge vid_clk);
        hs_pad_in = 1'b1;
    endtask

    // ---------------- main sequence ----------------
    initial begin
        bit saw_old;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        hs_pad_in = 1'b1; vs_pad_in = 1'b1;
        repeat (4) @(negedge vid_clk);
        check(hs_pad_oe == 1'b0, "R1 hs_pad_oe in reset", hs_pad_oe, 0);
        check(vs_pad_oe == 1'b0, "R1 vs_pad_oe in reset", vs_pad_oe, 0);
        check(hcount == 0, "R1 hcount in reset", int'(hcount), 0);
        check(vcount == 0, "R1 vcount in reset", int'(vcount), 0);
        check(hs_pad_out && vs_pad_out, "R1 sync outputs idle high", hs_pad_out & vs_pad_out, 1);
        run_model = 1'b1;
        rst_n = 1'b1;

        // free run, pads quiet (R2 R3)
        repeat (250) @(negedge vid_clk);

        // drive mode on both pads (R4 R6) with noisy pads (R9)
        wr(0, 3);
        check(hs_pad_oe && vs_pad_oe, "R6 direction takes effect next clock", hs_pad_oe & vs_pad_oe, 1);
        random_pins(400, 1, 1);

        // mid-frame rewrite of all timing values (R6 R10)
        do sample(); while (!(vcount == 3 && hcount == 2));
        wr(1, 15); wr(2, 2); wr(3, 3); wr(4, 13); wr(5, 4);
        wr(6, 7);  wr(7, 2); wr(8, 1); wr(9, 6);  wr(10, 2);
        saw_old = 0;
        do begin
            sample();
            if (hcount == 19) saw_old = 1;
        end while (!(vcount == 0 && hcount == 0));
        check(saw_old, "R6 old line total kept until frame start", saw_old, 1);
        do sample(); while (hcount != 15);
        sample();
        check(hcount == 0, "R6 R10 new line total after frame start", int'(hcount), 0);

        // horizontal follow mode (R7)
        wr(0, 2);
        repeat (6) @(negedge vid_clk);
        for (int p = 0; p < 3; p++) begin
            h_pulse_check(4);
            repeat ($urandom_range(25, 60)) @(negedge vid_clk);
        end
        random_pins(500, 1, 0);

        // offset above the total returns to zero after one clock (R2)
        wr(5, 30);
        wait_frame();
        repeat (4) @(negedge vid_clk);
        h_pulse_check(30);
        check(hcount == 30, "R2 out-of-range offset loaded", int'(hcount), 30);
        sample();
        check(hcount == 0, "R2 out-of-range count returns to zero", int'(hcount), 0);
        wr(5, 4);

        // vertical follow mode (R8)
        wr(0, 0);
        wait_frame();
        do sample(); while (!(hcount == 5 && vcount == 3));
        @(negedge vid_clk);
        vs_pad_in = 1'b0;
        repeat (4) @(negedge vid_clk);
        vs_pad_in = 1'b1;
        do sample(); while (hcount != 0);
        check(vcount == 2, "R8 vertical lock loads offset at line end", int'(vcount), 2);

        // both pads following with random traffic
        random_pins(1500, 1, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule